// File: doc/BRIEF.md
# Multi-Core Fault Capture and Alarm

This block watches the execution state of several processor cores and records hardware faults in one sticky status word per core. Each cycle a comparator stage looks at a core's execution mode, program counter and data-access address, plus two event strobes. It sets status bits for a program counter that runs past the end of its memory, for an access to memory that does not exist, for an indexed access that ends below zero, for a load that was initialised but never started, and for a halt the program asked for.

Monitor software reads the status words through a small register port, and each read clears the word it returns. The bits of all cores are OR-reduced into one alarm, which also serves as an interrupt request. Two 32-bit masks can be written through the same port. While the alarm is raised, the masks are ORed onto the two 32-bit output port buses, so a user-chosen pin such as an LED goes high when any fault is pending.

Top module: `fault_alarm_top`

## Requirements
- R1: A fault condition present on a core's inputs at a rising clock edge sets that core's status bit, and it reads back from the next cycle on. A set bit stays set until a clearing read of that core.
- R2: The execution mode is encoded 0 register-file, 1 lookup-RAM, 2 main-memory, 3 stopped. Status bit 0 is set when the mode is 0 and PC >= SPECIAL_BASE. Bit 1 is set when the mode is 1 and PC >= LUT_LIMIT. Bit 2 is set when the mode is 2 and PC >= RAM_TOP. In mode 3 no PC fault is flagged.
- R3: Each core's access address is ADDR_W+1 bits wide, and its MSB marks an index that resolved below zero. When access-valid is high, bit 4 is set if the MSB is 1, and bit 3 is set if the MSB is 0 and the low ADDR_W bits are >= RAM_TOP. When access-valid is low, neither bit is set.
- R4: A one-cycle init-without-start strobe sets bit 5, and a halt strobe sets bit 6.
- R5: Read data follows `reg_sel` combinationally. For a status word, bits 31..7 read as zero. A cycle with `reg_rd` high and `reg_sel` = k < N_CORES clears core k's word at the clock edge and leaves the other cores' words unchanged.
- R6: When a clearing read and a new fault event hit the same core in the same cycle, the new event's bit ends up set.
- R7: `err_flag` is the OR of every status bit of every core, and `irq` equals `err_flag`.
- R8: While `err_flag` is 0, each output port equals its input port. While it is 1, each output port equals its input port ORed with its mask.
- R9: Mask A is at address N_CORES and mask B at N_CORES+1. Both reset to zero, can be written with `reg_wr` and read back. A write to a status address changes nothing.
- R10: Status word k is at address k. Any address above N_CORES+1 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_mode | input | 2*N_CORES | Execution mode per core |
| core_pc | input | PC_W*N_CORES | Program counter per core |
| core_acc_valid | input | N_CORES | Data access valid per core |
| core_acc_addr | input | (ADDR_W+1)*N_CORES | Resolved access address per core, MSB = negative |
| core_init | input | N_CORES | Init-without-start strobe per core |
| core_halt | input | N_CORES | Halt strobe per core |
| reg_sel | input | SEL_W | Register select |
| reg_rd | input | 1 | Clearing read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| port_a_in | input | 32 | Port A value from the cores |
| port_b_in | input | 32 | Port B value from the cores |
| port_a_out | output | 32 | Port A value to the pins |
| port_b_out | output | 32 | Port B value to the pins |
| err_flag | output | 1 | Global fault indicator |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with three cores and RAM_TOP = 0x1000. The odd core count puts the two mask registers at addresses 3 and 4 and leaves addresses 5 to 7 unmapped, so the zero-read rule for unused addresses can be tested. The small RAM_TOP lets short directed values land on both sides of the top-of-RAM limit, for the main-memory PC check and the non-existent-address check. SPECIAL_BASE and LUT_LIMIT keep their defaults, so the register-file and lookup limits are tested at 0x1F0 and 0x400.

// File: rtl/fault_alarm_pkg.sv
package fault_alarm_pkg;

    typedef enum logic [1:0] {
        MODE_REGF = 2'd0,
        MODE_LUT  = 2'd1,
        MODE_MAIN = 2'd2,
        MODE_STOP = 2'd3
    } exec_mode_e;

    localparam int FLT_BITS   = 7;
    localparam int B_REGF_PC  = 0;
    localparam int B_LUT_PC   = 1;
    localparam int B_MAIN_PC  = 2;
    localparam int B_NO_MEM   = 3;
    localparam int B_NEG_IDX  = 4;
    localparam int B_INIT     = 5;
    localparam int B_HALT     = 6;

endpackage

// File: rtl/fault_detect.sv
module fault_detect
    import fault_alarm_pkg::*;
#(
    parameter int PC_W         = 20,
    parameter int ADDR_W       = 20,
    parameter int SPECIAL_BASE = 'h1F0,
    parameter int LUT_LIMIT    = 'h400,
    parameter int RAM_TOP      = 'h80000
) (
    input  logic [1:0]          mode,
    input  logic [PC_W-1:0]     pc,
    input  logic                acc_valid,
    input  logic [ADDR_W:0]     acc_addr,
    input  logic                init_pulse,
    input  logic                halt_pulse,
    output logic [FLT_BITS-1:0] events
);

    localparam logic [PC_W-1:0]   SPEC_PC = PC_W'(SPECIAL_BASE);
    localparam logic [PC_W-1:0]   LUT_PC  = PC_W'(LUT_LIMIT);
    localparam logic [PC_W-1:0]   RAM_PC  = PC_W'(RAM_TOP);
    localparam logic [ADDR_W-1:0] RAM_AD  = ADDR_W'(RAM_TOP);

    exec_mode_e m;
    logic       neg;

    always_comb begin
        m      = exec_mode_e'(mode);
        neg    = acc_addr[ADDR_W];
        events = '0;
        events[B_REGF_PC] = (m == MODE_REGF) && (pc >= SPEC_PC);
        events[B_LUT_PC]  = (m == MODE_LUT)  && (pc >= LUT_PC);
        events[B_MAIN_PC] = (m == MODE_MAIN) && (pc >= RAM_PC);
        events[B_NO_MEM]  = acc_valid && !neg && (acc_addr[ADDR_W-1:0] >= RAM_AD);
        events[B_NEG_IDX] = acc_valid && neg;
        events[B_INIT]    = init_pulse;
        events[B_HALT]    = halt_pulse;
    end

endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
    import fault_alarm_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES*FLT_BITS-1:0] ev_flat,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        err,
    output logic [DATA_W-1:0]           mask_a,
    output logic [DATA_W-1:0]           mask_b
);

    localparam logic [SEL_W-1:0] SEL_MA = SEL_W'(N_CORES);
    localparam logic [SEL_W-1:0] SEL_MB = SEL_W'(N_CORES + 1);

    typedef struct packed {
        logic [N_CORES-1:0][FLT_BITS-1:0] stat;
        logic [DATA_W-1:0]                mask_a;
        logic [DATA_W-1:0]                mask_b;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N_CORES; k++) begin
            logic [FLT_BITS-1:0] kept;
            kept = (rd_en && sel == SEL_W'(k)) ? '0 : st_q.stat[k];
            st_d.stat[k] = kept | ev_flat[k*FLT_BITS +: FLT_BITS];
        end
        if (wr_en && sel == SEL_MA) st_d.mask_a = wdata;
        if (wr_en && sel == SEL_MB) st_d.mask_b = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_CORES; k++) begin
            if (sel == SEL_W'(k)) rdata[FLT_BITS-1:0] = st_q.stat[k];
        end
        if (sel == SEL_MA) rdata = st_q.mask_a;
        if (sel == SEL_MB) rdata = st_q.mask_b;
    end

    assign err    = |st_q.stat;
    assign mask_a = st_q.mask_a;
    assign mask_b = st_q.mask_b;

endmodule

// File: rtl/pin_force.sv
module pin_force #(
    parameter int DATA_W = 32
) (
    input  logic              alarm,
    input  logic [DATA_W-1:0] pins_in,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] pins_out
);

    always_comb begin
        pins_out = pins_in | (alarm ? mask : '0);
    end

endmodule

// File: rtl/fault_alarm_top.sv
module fault_alarm_top
    import fault_alarm_pkg::*;
#(
    parameter int N_CORES      = 4,
    parameter int PC_W         = 20,
    parameter int ADDR_W       = 20,
    parameter int SPECIAL_BASE = 'h1F0,
    parameter int LUT_LIMIT    = 'h400,
    parameter int RAM_TOP      = 'h80000,
    localparam int SEL_W       = $clog2(N_CORES + 2),
    localparam int DATA_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*N_CORES-1:0]          core_mode,
    input  logic [PC_W*N_CORES-1:0]       core_pc,
    input  logic [N_CORES-1:0]            core_acc_valid,
    input  logic [(ADDR_W+1)*N_CORES-1:0] core_acc_addr,
    input  logic [N_CORES-1:0]            core_init,
    input  logic [N_CORES-1:0]            core_halt,
    input  logic [SEL_W-1:0]              reg_sel,
    input  logic                          reg_rd,
    input  logic                          reg_wr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [DATA_W-1:0]             port_a_in,
    input  logic [DATA_W-1:0]             port_b_in,
    output logic [DATA_W-1:0]             port_a_out,
    output logic [DATA_W-1:0]             port_b_out,
    output logic                          err_flag,
    output logic                          irq
);

    logic [N_CORES*FLT_BITS-1:0] ev_flat;
    logic [DATA_W-1:0]           mask_a_w, mask_b_w;
    logic                        alarm;

    for (genvar g = 0; g < N_CORES; g++) begin : g_det
        fault_detect #(
            .PC_W(PC_W), .ADDR_W(ADDR_W), .SPECIAL_BASE(SPECIAL_BASE),
            .LUT_LIMIT(LUT_LIMIT), .RAM_TOP(RAM_TOP)
        ) u_det (
            .mode      (core_mode[g*2 +: 2]),
            .pc        (core_pc[g*PC_W +: PC_W]),
            .acc_valid (core_acc_valid[g]),
            .acc_addr  (core_acc_addr[g*(ADDR_W+1) +: ADDR_W+1]),
            .init_pulse(core_init[g]),
            .halt_pulse(core_halt[g]),
            .events    (ev_flat[g*FLT_BITS +: FLT_BITS])
        );
    end

    fault_status_bank #(
        .N_CORES(N_CORES), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_flat(ev_flat),
        .sel    (reg_sel),
        .rd_en  (reg_rd),
        .wr_en  (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .err    (alarm),
        .mask_a (mask_a_w),
        .mask_b (mask_b_w)
    );

    pin_force #(.DATA_W(DATA_W)) u_force_a (
        .alarm(alarm), .pins_in(port_a_in), .mask(mask_a_w), .pins_out(port_a_out)
    );
    pin_force #(.DATA_W(DATA_W)) u_force_b (
        .alarm(alarm), .pins_in(port_b_in), .mask(mask_b_w), .pins_out(port_b_out)
    );

    assign err_flag = alarm;
    assign irq      = alarm;

endmodule

// File: rtl/fault_alarm_chk.sv
module fault_alarm_chk #(
    parameter int N_CORES = 4,
    parameter int SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   reg_sel,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic [N_CORES-1:0] core_init,
    input logic [N_CORES-1:0] core_halt,
    input logic [31:0]        port_a_in,
    input logic [31:0]        port_b_in,
    input logic [31:0]        port_a_out,
    input logic [31:0]        port_b_out,
    input logic [31:0]        mask_a,
    input logic [31:0]        mask_b,
    input logic               err_flag
);

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !reg_rd |=> err_flag); // R1

    AST_STROBE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_init) || (|core_halt) |=> err_flag); // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel < SEL_W'(N_CORES)) |-> reg_rdata[31:7] == '0); // R5

    AST_QUIET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> (port_a_out == port_a_in) && (port_b_out == port_b_in)); // R8

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> ((port_a_out & mask_a) == mask_a) && ((port_b_out & mask_b) == mask_b)); // R8

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel == SEL_W'(N_CORES) |=> mask_a == $past(reg_wdata)); // R9

endmodule

bind fault_alarm_top fault_alarm_chk #(.N_CORES(N_CORES), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .core_init (core_init),
    .core_halt (core_halt),
    .port_a_in (port_a_in),
    .port_b_in (port_b_in),
    .port_a_out(port_a_out),
    .port_b_out(port_b_out),
    .mask_a    (mask_a_w),
    .mask_b    (mask_b_w),
    .err_flag  (err_flag)
);

// File: tb/fault_alarm_top_tb.sv
module fault_alarm_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 3;
    localparam int PW  = 20;
    localparam int AW  = 20;
    localparam int SW  = $clog2(N + 2);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2*N-1:0]    core_mode;
    logic [PW*N-1:0]   core_pc;
    logic [N-1:0]      core_acc_valid;
    logic [(AW+1)*N-1:0] core_acc_addr;
    logic [N-1:0]      core_init, core_halt;
    logic [SW-1:0]     reg_sel;
    logic              reg_rd, reg_wr;
    logic [31:0]       reg_wdata, reg_rdata;
    logic [31:0]       port_a_in, port_b_in, port_a_out, port_b_out;
    logic              err_flag, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_alarm_top #(.N_CORES(N), .PC_W(PW), .ADDR_W(AW), .RAM_TOP('h1000)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_mode(core_mode), .core_pc(core_pc),
        .core_acc_valid(core_acc_valid), .core_acc_addr(core_acc_addr),
        .core_init(core_init), .core_halt(core_halt), .reg_sel(reg_sel),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_a_in(port_a_in), .port_b_in(port_b_in), .port_a_out(port_a_out),
        .port_b_out(port_b_out), .err_flag(err_flag), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        core_mode      = {N{2'd3}};
        core_pc        = '0;
        core_acc_valid = '0;
        core_acc_addr  = '0;
        core_init      = '0;
        core_halt      = '0;
        reg_rd = 0; reg_wr = 0; reg_wdata = '0; reg_sel = '0;
    endtask

    task automatic peek(int sel, output logic [31:0] v);
        reg_sel = SW'(sel);
        #1 v = reg_rdata;
    endtask

    task automatic clear_all();
        reg_rd = 1;
        for (int k = 0; k < N; k++) begin
            reg_sel = SW'(k);
            step();
        end
        reg_rd = 0;
    endtask

    // one cycle of a PC value in a mode on core k
    task automatic pc_cycle(int k, logic [1:0] m, logic [PW-1:0] pc);
        core_mode[k*2 +: 2] = m;
        core_pc[k*PW +: PW] = pc;
        step();
        core_mode[k*2 +: 2] = 2'd3;
        core_pc[k*PW +: PW] = '0;
    endtask

    task automatic acc_cycle(int k, logic v, logic [AW:0] a);
        core_acc_valid[k] = v;
        core_acc_addr[k*(AW+1) +: AW+1] = a;
        step();
        core_acc_valid[k] = 0;
        core_acc_addr[k*(AW+1) +: AW+1] = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < N + 2; s++) begin
            peek(s, v);
            check("R9/R5 reset word", v, 32'h0);
        end
        check("R7 reset err", {31'b0, err_flag}, 0);
        check("R8 reset pass A", port_a_out, port_a_in);
    endtask

    task automatic t_pc_faults();
        logic [31:0] v;
        pc_cycle(0, 2'd0, 'h1EF);
        peek(0, v); check("R2 regfile below limit", v, 0);
        pc_cycle(0, 2'd0, 'h1F0);
        peek(0, v); check("R2 regfile at limit bit0", v, 32'h01);
        pc_cycle(1, 2'd1, 'h3FF);
        pc_cycle(1, 2'd1, 'h1F0);
        peek(1, v); check("R2 lookup below limit", v, 0);
        pc_cycle(1, 2'd1, 'h400);
        peek(1, v); check("R2 lookup limit bit1", v, 32'h02);
        pc_cycle(2, 2'd2, 'hFFF);
        pc_cycle(2, 2'd3, 'hFFFFF);
        peek(2, v); check("R2 main below / stopped", v, 0);
        pc_cycle(2, 2'd2, 'h1000);
        peek(2, v); check("R2 main top bit2", v, 32'h04);
        step();
        peek(0, v); check("R1 sticky after idle", v, 32'h01);
        clear_all();
    endtask

    task automatic t_access();
        logic [31:0] v;
        acc_cycle(1, 1, 21'h00FFF);
        peek(1, v); check("R3 valid in range", v, 0);
        acc_cycle(1, 0, 21'h100000);
        acc_cycle(1, 0, 21'h01000);
        peek(1, v); check("R3 invalid ignored", v, 0);
        acc_cycle(1, 1, 21'h01000);
        peek(1, v); check("R3 nonexistent bit3", v, 32'h08);
        acc_cycle(1, 1, 21'h100001);
        peek(1, v); check("R3 negative bit4", v, 32'h18);
        clear_all();
    endtask

    task automatic t_strobes();
        logic [31:0] v;
        core_init[2] = 1; step(); core_init[2] = 0;
        peek(2, v); check("R4 init bit5", v, 32'h20);
        core_halt[0] = 1; step(); core_halt[0] = 0;
        peek(0, v); check("R4 halt bit6", v, 32'h40);
        clear_all();
    endtask

    task automatic t_read_clear();
        logic [31:0] v;
        core_halt[0] = 1; core_init[1] = 1; step();
        core_halt[0] = 0; core_init[1] = 0;
        reg_sel = 0; reg_rd = 1;
        #1 check("R5 read returns word", reg_rdata, 32'h40);
        step(); reg_rd = 0;
        peek(0, v); check("R5 read cleared", v, 0);
        peek(1, v); check("R5 other core kept", v, 32'h20);
        clear_all();
        check("R7 all clear err low", {31'b0, err_flag}, 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pc_cycle(0, 2'd0, 'h1FF);
        reg_sel = 0; reg_rd = 1; core_halt[0] = 1;
        step();
        reg_rd = 0; core_halt[0] = 0;
        peek(0, v); check("R6 event wins over clear", v, 32'h40);
        clear_all();
    endtask

    task automatic t_alarm_pins();
        port_a_in = 32'h0000_00F0; port_b_in = 32'h1200_0000;
        reg_wr = 1; reg_sel = SW'(N); reg_wdata = 32'h8000_0001; step();
        reg_sel = SW'(N+1); reg_wdata = 32'h0000_0100; step();
        reg_wr = 0;
        #1 check("R8 quiet port A", port_a_out, 32'h0000_00F0);
        check("R8 quiet port B", port_b_out, 32'h1200_0000);
        check("R7 quiet irq", {31'b0, irq}, 0);
        acc_cycle(2, 1, 21'h1FFFFF);
        #1 check("R7 err set", {31'b0, err_flag}, 1);
        check("R7 irq set", {31'b0, irq}, 1);
        check("R8 forced A", port_a_out, 32'h8000_00F1);
        check("R8 forced B", port_b_out, 32'h1200_0100);
        clear_all();
        #1 check("R8 released A", port_a_out, 32'h0000_00F0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] v;
        peek(N, v); check("R9 mask A readback", v, 32'h8000_0001);
        peek(N+1, v); check("R9 mask B readback", v, 32'h0000_0100);
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'hFFFF_FFFF; step(); reg_wr = 0;
        peek(1, v); check("R9 status write ignored", v, 0);
        check("R9 no alarm from write", {31'b0, err_flag}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        core_halt = '1; step(); core_halt = '0;
        for (int s = N + 2; s < (1 << SW); s++) begin
            peek(s, v); check("R10 unmapped reads zero", v, 0);
        end
        peek(2, v); check("R10 core2 at address 2", v, 32'h40);
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        port_a_in = 32'h0000_5A5A; port_b_in = 32'hA5A5_0000;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_pc_faults();
        t_access();
        t_strobes();
        t_read_clear();
        t_collision();
        t_alarm_pins();
        t_mask_rw();
        t_map();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule